// File: doc/BRIEF.md
# Fracturable Six-Input Lookup Table

This block is one programmable logic cell. It holds a 64-bit truth table, split into a lower and an upper 32-bit half. The two halves are read with the same five low select bits. In whole mode, one output gives an arbitrary function of all six select bits: the top select bit picks the half. In pair mode, the cell gives two unrelated functions of the same five select bits. The wide output carries the upper-half function and the low output carries the lower-half function.

The table is filled through a one-bit serial port, one bit per clock while the shift enable is high. It stands in for a configuration stream. Once a complete table is in place, both outputs are plain indexed reads of the stored bits. No logic depends on the function that was programmed, so the output path is the same whatever the table holds. Until a full table has been shifted in, and at any time the shift enable is high, both outputs are held low.

Top module: `flut6_cell`

## Requirements
- R1: After a synchronous reset, `cfg_ready` is 0 and both outputs are 0.
- R2: In whole mode (`pair_mode`=0), with the cell ready and not shifting, `y_wide` equals table bit number `sel`. Table bits 32..63 form the upper half and are selected when `sel[5]`=1.
- R3: `cfg_ready` goes high on the clock edge that takes the 64th bit of an unbroken run of enabled clocks. It then stays high until reset.
- R4: While `cfg_ready` is 0, `y_wide` and `y_low` are both 0 for any select value.
- R5: While `cfg_shift_en` is 1, both outputs are 0, even when the cell is already ready.
- R6: With the cell ready and not shifting, `y_low` equals table bit `sel[4:0]` (the lower half) in both modes.
- R7: In pair mode (`pair_mode`=1), `y_wide` equals table bit 32+`sel[4:0]`, and `sel[5]` has no effect on either output.
- R8: The first bit shifted in lands at table index 63 and the last at index 0.
- R9: If the shift enable drops before 64 bits, the count starts again, `cfg_ready` stays 0, and a later full run of 64 bits sets it.
- R10: A second full load after the cell is ready replaces every table bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_shift_en | input | 1 | Shift one table bit in per clock while high |
| cfg_bit | input | 1 | Serial table bit, highest index first |
| pair_mode | input | 1 | 0: one six-input function, 1: two five-input functions |
| sel | input | 6 | Lookup select inputs |
| y_wide | output | 1 | Six-input result, or upper-half result in pair mode |
| y_low | output | 1 | Lower-half result on the five low select bits |
| cfg_ready | output | 1 | A full table has been loaded |

## Verification
Two things can happen in the same cycle: a lookup on a cell that is already ready, and the start of a reload. The bench provokes this by reloading a ready cell with a different table while `sel` stays fixed. It expects both outputs to be 0 for every cycle the shift enable is high, and it expects the new table to answer once the enable drops. The other overlap is the 64th shift edge, where `cfg_ready` rises. The bench checks that `cfg_ready` is still low just before that edge and high just after it. It also checks that a broken run of shifts never raises it.

// File: rtl/flut_pkg.sv
package flut_pkg;

  typedef enum logic {
    MODE_WHOLE = 1'b0,
    MODE_PAIR  = 1'b1
  } flut_mode_e;

  function automatic int unsigned table_bits(input int unsigned sel_w);
    return 32'd1 << sel_w;
  endfunction

endpackage

// File: rtl/flut_cfg_shifter.sv
module flut_cfg_shifter #(
  parameter int unsigned DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             shift_in,
  output logic [DEPTH-1:0] table_q,
  output logic             loaded
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [CNT_W-1:0] run_cnt;

  // Bits enter at index 0 and move toward DEPTH-1, so the first one ends up on top.
  always_ff @(posedge clk) begin
    if (rst) begin
      table_q <= '0;
      run_cnt <= '0;
      loaded  <= 1'b0;
    end else if (shift_en) begin
      table_q <= {table_q[DEPTH-2:0], shift_in};
      if (run_cnt == LAST) loaded <= 1'b1;
      if (run_cnt != FULL) run_cnt <= run_cnt + 1'b1;
    end else begin
      run_cnt <= '0;
    end
  end

endmodule

// File: rtl/flut_half.sv
module flut_half #(
  parameter int unsigned IDX_W = 5
) (
  input  logic [(1<<IDX_W)-1:0] bits,
  input  logic [IDX_W-1:0]      idx,
  output logic                  dout
);
  // Plain indexed read: the path does not depend on the stored function.
  assign dout = bits[idx];
endmodule

// File: rtl/flut6_cell.sv
module flut6_cell
  import flut_pkg::*;
#(
  parameter int unsigned SEL_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_shift_en,
  input  logic             cfg_bit,
  input  logic             pair_mode,
  input  logic [SEL_W-1:0] sel,
  output logic             y_wide,
  output logic             y_low,
  output logic             cfg_ready
);
  localparam int unsigned DEPTH = table_bits(SEL_W);
  localparam int unsigned HALF  = DEPTH / 2;
  localparam int unsigned LOW_W = SEL_W - 1;

  logic [DEPTH-1:0] cfg_table;
  logic [1:0]       half_out;
  flut_mode_e       mode;
  logic             upper_pick;
  logic             wide_raw;
  logic             out_gate;

  flut_cfg_shifter #(.DEPTH(DEPTH)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .shift_en (cfg_shift_en),
    .shift_in (cfg_bit),
    .table_q  (cfg_table),
    .loaded   (cfg_ready)
  );

  for (genvar g = 0; g < 2; g++) begin : g_half
    flut_half #(.IDX_W(LOW_W)) u_half (
      .bits (cfg_table[g*HALF +: HALF]),
      .idx  (sel[LOW_W-1:0]),
      .dout (half_out[g])
    );
  end

  assign mode       = flut_mode_e'(pair_mode);
  assign upper_pick = (mode == MODE_PAIR) | sel[SEL_W-1];
  assign wide_raw   = upper_pick ? half_out[1] : half_out[0];
  assign out_gate   = cfg_ready & ~cfg_shift_en;
  assign y_wide     = out_gate & wide_raw;
  assign y_low      = out_gate & half_out[0];

endmodule

// File: rtl/flut6_cell_chk.sv
module flut6_cell_chk #(
  parameter int unsigned SEL_W = 6
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  cfg_shift_en,
  input logic                  pair_mode,
  input logic [SEL_W-1:0]      sel,
  input logic                  y_wide,
  input logic                  y_low,
  input logic                  cfg_ready,
  input logic [(1<<SEL_W)-1:0] cfg_table
);
  logic live;
  assign live = cfg_ready && !cfg_shift_en;

  a_r4_quiet_unloaded: assert property (@(posedge clk) disable iff (rst)
    !cfg_ready |-> (!y_wide && !y_low));

  a_r5_quiet_shifting: assert property (@(posedge clk) disable iff (rst)
    cfg_shift_en |-> (!y_wide && !y_low));

  a_r3_ready_sticky: assert property (@(posedge clk) disable iff (rst)
    cfg_ready |=> cfg_ready);

  a_r3_ready_from_shift: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_ready) |-> $past(cfg_shift_en));

  a_r6_low_half: assert property (@(posedge clk) disable iff (rst)
    live |-> (y_low == cfg_table[{1'b0, sel[SEL_W-2:0]}]));

  a_r2_whole_read: assert property (@(posedge clk) disable iff (rst)
    (live && !pair_mode) |-> (y_wide == cfg_table[sel]));

  a_r7_pair_upper: assert property (@(posedge clk) disable iff (rst)
    (live && pair_mode) |-> (y_wide == cfg_table[{1'b1, sel[SEL_W-2:0]}]));

endmodule

bind flut6_cell flut6_cell_chk #(.SEL_W(SEL_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_shift_en (cfg_shift_en),
  .pair_mode    (pair_mode),
  .sel          (sel),
  .y_wide       (y_wide),
  .y_low        (y_low),
  .cfg_ready    (cfg_ready),
  .cfg_table    (cfg_table)
);

// File: tb/sim_flut6_cell.sv
module sim_flut6_cell;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_shift_en = 1'b0;
  logic       cfg_bit = 1'b0;
  logic       pair_mode = 1'b0;
  logic [5:0] sel = '0;
  logic       y_wide, y_low, cfg_ready;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flut6_cell u0 (
    .clk(clk), .rst(rst), .cfg_shift_en(cfg_shift_en), .cfg_bit(cfg_bit),
    .pair_mode(pair_mode), .sel(sel), .y_wide(y_wide), .y_low(y_low),
    .cfg_ready(cfg_ready)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b sel=%0d mode=%0b", tag, act, exp, sel, pair_mode);
    end
  endtask

  function automatic logic exp_wide(input logic [63:0] t, input logic m, input logic [5:0] s);
    return m ? t[{1'b1, s[4:0]}] : t[s];
  endfunction

  function automatic logic exp_low(input logic [63:0] t, input logic [5:0] s);
    return t[{1'b0, s[4:0]}];
  endfunction

  // Shift a table in, highest index first; optionally check the ready edge (R3).
  task automatic load_table(input logic [63:0] t, input bit check_edge);
    for (int i = 63; i >= 0; i--) begin
      @(negedge clk);
      cfg_shift_en = 1'b1;
      cfg_bit = t[i];
      if (i == 32) begin
        #1;
        chk("R5 wide quiet while shifting", y_wide, 1'b0);
        chk("R5 low quiet while shifting", y_low, 1'b0);
      end
      if (i == 0 && check_edge) chk("R3 not ready before 64th edge", cfg_ready, 1'b0);
    end
    @(negedge clk);
    cfg_shift_en = 1'b0;
    if (check_edge) chk("R3 ready after 64th edge", cfg_ready, 1'b1);
  endtask

  task automatic sweep(input logic [63:0] t, input logic m, input string tag);
    pair_mode = m;
    for (int s = 0; s < 64; s++) begin
      sel = 6'(s);
      #1;
      chk(m ? "R7 pair wide" : "R2 whole wide", y_wide, exp_wide(t, m, sel));
      chk("R6 low half", y_low, exp_low(t, sel));
      if (s == 63) chk(tag, y_wide, exp_wide(t, m, sel));
    end
  endtask

  initial begin
    logic [63:0] tbl;
    void'($urandom(32'h1a2b3c4d));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 ready after reset", cfg_ready, 1'b0);
    chk("R1 wide after reset", y_wide, 1'b0);
    chk("R1 low after reset", y_low, 1'b0);
    for (int s = 0; s < 64; s += 9) begin
      sel = 6'(s); pair_mode = s[0];
      #1;
      chk("R4 wide unloaded", y_wide, 1'b0);
      chk("R4 low unloaded", y_low, 1'b0);
    end

    // R9: broken run of 30 shifts does not count.
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); cfg_shift_en = 1'b1; cfg_bit = 1'b1;
    end
    @(negedge clk); cfg_shift_en = 1'b0;
    @(negedge clk);
    chk("R9 ready after short run", cfg_ready, 1'b0);

    // R8: single-hot tables reveal load order; upper/lower split checks R2.
    tbl = 64'h8000_0000_0000_0000;
    load_table(tbl, 1'b1);
    sel = 6'd63; pair_mode = 1'b0; #1;
    chk("R8 first bit at index 63", y_wide, 1'b1);
    sel = 6'd0; #1;
    chk("R8 index 0 clear", y_wide, 1'b0);
    sweep(tbl, 1'b0, "R2 hot63 whole");

    tbl = 64'h0000_0000_0000_0001;
    load_table(tbl, 1'b0);
    sel = 6'd0; pair_mode = 1'b0; #1;
    chk("R8 last bit at index 0", y_wide, 1'b1);
    chk("R10 reload replaced index 63", exp_wide(tbl, 1'b0, 6'd63), 1'b0);
    sel = 6'd63; #1;
    chk("R10 old bit 63 gone", y_wide, 1'b0);

    tbl = 64'hFFFF_FFFF_0000_0000;
    load_table(tbl, 1'b0);
    sweep(tbl, 1'b0, "R2 upper half by sel5");
    sweep(tbl, 1'b1, "R7 pair upper all ones");
    for (int s = 0; s < 32; s += 5) begin
      pair_mode = 1'b1;
      sel = {1'b0, 5'(s)}; #1;
      chk("R7 sel5 ignored wide low", y_wide, 1'b1);
      sel = {1'b1, 5'(s)}; #1;
      chk("R7 sel5 ignored wide high", y_wide, 1'b1);
      chk("R7 sel5 ignored low", y_low, 1'b0);
    end

    tbl = '0;
    load_table(tbl, 1'b0);
    sweep(tbl, 1'b0, "R10 all zero");
    tbl = '1;
    load_table(tbl, 1'b0);
    sweep(tbl, 1'b1, "R10 all ones");

    for (int r = 0; r < 6; r++) begin
      tbl = {$urandom(), $urandom()};
      sel = 6'(r * 11);
      load_table(tbl, 1'b0);
      sweep(tbl, 1'b0, "R2 random whole");
      sweep(tbl, 1'b1, "R7 random pair");
    end

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 ready cleared by reset", cfg_ready, 1'b0);
    chk("R4 wide after second reset", y_wide, 1'b0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule